// File: doc/BRIEF.md
# Match-Interrupt Watchdog Timer with Configuration Lock

This block is a watchdog that counts on a slow low-power clock while software reaches it through a simple register port on the bus clock. A 16-bit up-counter runs freely while the watchdog is enabled. Whenever its low bits equal a programmed match value, it raises a pending interrupt. The number of upper counter bits that take part in the comparison is programmable, so the effective period can be shortened to a power of two. The counter is never reset by a match. It runs on, wraps and matches again one effective period later.

Software feeds the watchdog by clearing the pending interrupt. Clearing also empties an internal count of unserviced matches. If three matches occur with no clear in between, the block raises a reset request that stays high until the slow-domain system reset. A masking bit gates only the interrupt output and never the reset. A two-step unlock sequence guards the control, match and ignore-bit settings, and a wake-from-sleep input forces the lock closed.

Every bus-side change reaches the slow domain through a toggle handshake. A request issued while the previous one is still in flight is held back, not lost. The counter returns to the bus through a Gray-coded two-flop path.

Top module: `wdg_top`

## Requirements
- R1: While enabled, the counter advances by exactly one on every slow clock cycle and wraps through zero. A match does not clear it. While disabled, it holds its value. It is read at register address 3.
- R2: A match occurs when the counter and the match value (address 1) agree in their low 16−k bits, where k is the ignore-bit field (address 2, bits 3:0). A match sets the pending flag, which reads as bit 0 of address 4.
- R3: With no clear, the third match after counting starts from zero raises rst_req. This happens after match + 2·2^(16−k) counting cycles.
- R4: Writing 1 to bit 0 of address 4 clears the pending flag and the count of unserviced matches. Clears issued at least every effective period keep rst_req low.
- R5: Once raised, rst_req stays high until rst_lf is applied. Bus writes do not lower it.
- R6: irq equals the pending flag ANDed with the mask bit (address 5, bit 0, 1 = pass). The mask bit has no effect on rst_req.
- R7: Address 6 holds a 2-bit lock field. Writing 3 locks the block. From the locked state, a write of 1 followed by a write of 2 unlocks it. The lock field reads 0 when open, 1 after the first unlock step and 3 when locked. While not open, writes to control (address 0, bit 0 = enable), match and ignore-bit registers are dropped.
- R8: A pulse on wake_lock forces the lock field to the locked state.
- R9: A write to address 3 zeroes the counter only while the watchdog is disabled. While enabled, the write is ignored.
- R10: After reset, the registers read as follows: control 0, match 4096, ignore 0, counter 0, pending 0, mask 1 and lock 0. irq and rst_req are both low.
- R11: A write that turns enable from 0 to 1 also clears the pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Register port clock |
| rst_bus | input | 1 | Synchronous active-high reset, bus domain |
| clk_lf | input | 1 | Slow counting clock |
| rst_lf | input | 1 | Synchronous active-high system reset, slow domain |
| wake_lock | input | 1 | Sleep-exit pulse that forces the lock closed |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 3 | Write register address |
| wr_data | input | 16 | Write data |
| rd_sel | input | 3 | Read register address |
| rd_data | output | 16 | Read data (combinational from rd_sel) |
| irq | output | 1 | Masked match interrupt |
| rst_req | output | 1 | Watchdog reset request, slow domain |

## Verification
Each bus write is registered once in the bus domain. It then crosses two slow synchronizer flops and one edge-detect flop, so a setting takes effect three to five slow cycles after the write. Status and counter values read back two bus cycles plus one slow cycle after they change.

The bench therefore never samples a cross-domain result on a fixed cycle. For the reset timing, it counts slow cycles from the enable write until rst_req rises. It then accepts a window of a few cycles beyond the third-match point. The window is narrow enough that the second or fourth match would fall outside it.

Before reading the counter or status, the bench waits at least six slow cycles. It reads bus-side registers two bus cycles after a write.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int CNT_W      = 16;
    localparam int IGN_W      = $clog2(CNT_W);
    localparam int ADDR_W     = 3;
    localparam int LK_W       = 2;
    localparam int MISS_W     = 2;
    localparam int MISS_LIMIT = 2;
    localparam logic [CNT_W-1:0] MATCH_DFLT = CNT_W'(4096);

    localparam int EV_CFG    = 0;
    localparam int EV_INTCLR = 1;
    localparam int EV_CNTCLR = 2;
    localparam int EV_N      = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL  = 3'd0,
        A_MATCH = 3'd1,
        A_IGN   = 3'd2,
        A_CNT   = 3'd3,
        A_INT   = 3'd4,
        A_MASK  = 3'd5,
        A_LOCK  = 3'd6
    } addr_e;

    typedef enum logic [LK_W-1:0] {
        LK_OPEN = 2'd0,
        LK_HALF = 2'd1,
        LK_SHUT = 2'd3
    } lk_e;

    typedef struct packed {
        logic             en;
        logic [IGN_W-1:0] ign;
        logic [CNT_W-1:0] match;
    } cfg_t;

    localparam cfg_t CFG_RST = '{en: 1'b0, ign: '0, match: MATCH_DFLT};

    function automatic logic [CNT_W-1:0] keep_mask(input logic [IGN_W-1:0] ign);
        return {CNT_W{1'b1}} >> ign;
    endfunction

    function automatic logic [CNT_W-1:0] bin2gray(input logic [CNT_W-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [CNT_W-1:0] gray2bin(input logic [CNT_W-1:0] g);
        logic [CNT_W-1:0] b;
        b[CNT_W-1] = g[CNT_W-1];
        for (int i = CNT_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    function automatic lk_e lk_step(input lk_e cur, input logic [LK_W-1:0] v);
        lk_e nxt;
        nxt = cur;
        if (v == 2'd3) begin
            nxt = LK_SHUT;
        end else begin
            case (cur)
                LK_SHUT: if (v == 2'd1) nxt = LK_HALF;
                LK_HALF: nxt = (v == 2'd2) ? LK_OPEN : LK_SHUT;
                default: nxt = cur;
            endcase
        end
        return nxt;
    endfunction

endpackage

// File: rtl/wdg_sync2.sv
module wdg_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/wdg_evt_xfer.sv
module wdg_evt_xfer (
    input  logic clk_a,
    input  logic rst_a,
    input  logic req_a,
    input  logic clk_b,
    input  logic rst_b,
    output logic pls_b
);
    logic tgl_a;
    logic que_a;
    logic ack_a;
    logic busy_a;
    logic s_b;
    logic d_b;

    wdg_sync2 #(.W(1)) u_fwd (.clk(clk_b), .rst(rst_b), .d(tgl_a), .q(s_b));

    always_ff @(posedge clk_b) begin
        if (rst_b) d_b <= 1'b0;
        else       d_b <= s_b;
    end

    assign pls_b = s_b ^ d_b;

    wdg_sync2 #(.W(1)) u_back (.clk(clk_a), .rst(rst_a), .d(d_b), .q(ack_a));

    assign busy_a = tgl_a ^ ack_a;

    always_ff @(posedge clk_a) begin
        if (rst_a) begin
            tgl_a <= 1'b0;
            que_a <= 1'b0;
        end else if (req_a || que_a) begin
            if (!busy_a) begin
                tgl_a <= ~tgl_a;
                que_a <= 1'b0;
            end else begin
                que_a <= 1'b1;
            end
        end
    end

    // R4: a request arriving during a transfer is kept for later
    a_r4_req_kept: assert property (@(posedge clk_a) disable iff (rst_a)
        (req_a && busy_a) |=> que_a);

    // R4: a toggle never changes while the previous one is unacknowledged
    a_r4_one_in_flight: assert property (@(posedge clk_a) disable iff (rst_a)
        busy_a |=> (tgl_a == $past(tgl_a)));
endmodule

// File: rtl/wdg_regs.sv
module wdg_regs
    import wdg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wake_lock,
    input  logic             wr_en,
    input  logic [ADDR_W-1:0] wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_sel,
    output logic [CNT_W-1:0] rd_data,
    input  logic             pend_lf,
    input  logic [CNT_W-1:0] cnt_gray_lf,
    output cfg_t             cfg,
    output logic [EV_N-1:0]  ev_req,
    output logic             irq
);
    lk_e              lk;
    logic             mask_q;
    logic             wr_open;
    logic             pend_s;
    logic [CNT_W-1:0] gray_s;
    logic [CNT_W-1:0] cnt_bin;
    addr_e            wsel;

    assign wsel    = addr_e'(wr_sel);
    assign wr_open = (lk == LK_OPEN) && !wake_lock;

    always_ff @(posedge clk) begin
        if (rst) begin
            lk     <= LK_OPEN;
            cfg    <= CFG_RST;
            mask_q <= 1'b1;
            ev_req <= '0;
        end else begin
            ev_req <= '0;
            if (wake_lock) begin
                lk <= LK_SHUT;
            end else if (wr_en && wsel == A_LOCK) begin
                lk <= lk_step(lk, wr_data[LK_W-1:0]);
            end
            if (wr_en && wr_open) begin
                case (wsel)
                    A_CTRL: begin
                        cfg.en         <= wr_data[0];
                        ev_req[EV_CFG] <= 1'b1;
                        if (wr_data[0] && !cfg.en) ev_req[EV_INTCLR] <= 1'b1;
                    end
                    A_MATCH: begin
                        cfg.match      <= wr_data;
                        ev_req[EV_CFG] <= 1'b1;
                    end
                    A_IGN: begin
                        cfg.ign        <= wr_data[IGN_W-1:0];
                        ev_req[EV_CFG] <= 1'b1;
                    end
                    default: ;
                endcase
            end
            if (wr_en) begin
                case (wsel)
                    A_CNT:  ev_req[EV_CNTCLR] <= 1'b1;
                    A_INT:  if (wr_data[0]) ev_req[EV_INTCLR] <= 1'b1;
                    A_MASK: mask_q <= wr_data[0];
                    default: ;
                endcase
            end
        end
    end

    wdg_sync2 #(.W(1))     u_pend (.clk(clk), .rst(rst), .d(pend_lf),     .q(pend_s));
    wdg_sync2 #(.W(CNT_W)) u_cnt  (.clk(clk), .rst(rst), .d(cnt_gray_lf), .q(gray_s));

    assign cnt_bin = gray2bin(gray_s);
    assign irq     = pend_s & mask_q;

    always_comb begin
        rd_data = '0;
        case (addr_e'(rd_sel))
            A_CTRL:  rd_data[0]         = cfg.en;
            A_MATCH: rd_data            = cfg.match;
            A_IGN:   rd_data[IGN_W-1:0] = cfg.ign;
            A_CNT:   rd_data            = cnt_bin;
            A_INT:   rd_data[0]         = pend_s;
            A_MASK:  rd_data[0]         = mask_q;
            A_LOCK:  rd_data[LK_W-1:0]  = lk;
            default: rd_data            = '0;
        endcase
    end

    a_r7_locked_match_kept: assert property (@(posedge clk) disable iff (rst)
        (!wr_open && wr_en && wsel == A_MATCH) |=> $stable(cfg.match));

    a_r7_locked_enable_kept: assert property (@(posedge clk) disable iff (rst)
        (!wr_open && wr_en && wsel == A_CTRL) |=> $stable(cfg.en));

    a_r7_two_steps: assert property (@(posedge clk) disable iff (rst)
        (lk == LK_SHUT) |=> (lk != LK_OPEN));

    a_r8_wake_locks: assert property (@(posedge clk) disable iff (rst)
        wake_lock |=> (lk == LK_SHUT));
endmodule

// File: rtl/wdg_core.sv
module wdg_core
    import wdg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  cfg_t             cfg_bus,
    input  logic             cfg_ld,
    input  logic             int_clr,
    input  logic             cnt_clr,
    output logic             pend,
    output logic             rst_req,
    output logic [CNT_W-1:0] cnt_gray
);
    cfg_t              cfg_l;
    logic [CNT_W-1:0]  cnt;
    logic [MISS_W-1:0] miss;
    logic [MISS_W-1:0] miss_base;
    logic              hit;

    assign hit       = cfg_l.en && (((cnt ^ cfg_l.match) & keep_mask(cfg_l.ign)) == '0);
    assign miss_base = int_clr ? '0 : miss;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_l    <= CFG_RST;
            cnt      <= '0;
            miss     <= '0;
            pend     <= 1'b0;
            rst_req  <= 1'b0;
            cnt_gray <= '0;
        end else begin
            if (cfg_ld) cfg_l <= cfg_bus;

            if (cfg_l.en)     cnt <= cnt + 1'b1;
            else if (cnt_clr) cnt <= '0;

            if (hit) begin
                pend <= 1'b1;
                if (miss_base == MISS_W'(MISS_LIMIT)) rst_req <= 1'b1;
                else                                  miss    <= miss_base + 1'b1;
            end else begin
                miss <= miss_base;
                if (int_clr) pend <= 1'b0;
            end

            cnt_gray <= bin2gray(cnt);
        end
    end

    a_r1_count_step: assert property (@(posedge clk) disable iff (rst)
        cfg_l.en |=> (cnt == $past(cnt) + 1'b1));

    a_r1_count_hold: assert property (@(posedge clk) disable iff (rst)
        (!cfg_l.en && !cnt_clr) |=> $stable(cnt));

    a_r9_clear_ignored: assert property (@(posedge clk) disable iff (rst)
        (cfg_l.en && cnt_clr) |=> (cnt != '0 || $past(cnt) == '1));

    a_r3_third_hit: assert property (@(posedge clk) disable iff (rst)
        (hit && !int_clr && miss == MISS_W'(MISS_LIMIT)) |=> rst_req);

    a_r4_clear_empties: assert property (@(posedge clk) disable iff (rst)
        (int_clr && !hit) |=> (!pend && miss == '0));

    a_r5_reset_held: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> rst_req);
endmodule

// File: rtl/wdg_top.sv
module wdg_top
    import wdg_pkg::*;
(
    input  logic                    clk_bus,
    input  logic                    rst_bus,
    input  logic                    clk_lf,
    input  logic                    rst_lf,
    input  logic                    wake_lock,
    input  logic                    wr_en,
    input  logic [2:0]              wr_sel,
    input  logic [15:0]             wr_data,
    input  logic [2:0]              rd_sel,
    output logic [15:0]             rd_data,
    output logic                    irq,
    output logic                    rst_req
);
    cfg_t             cfg;
    logic [EV_N-1:0]  ev_req;
    logic [EV_N-1:0]  ev_pls;
    logic             pend;
    logic [CNT_W-1:0] cnt_gray;

    wdg_regs u_regs (
        .clk        (clk_bus),
        .rst        (rst_bus),
        .wake_lock  (wake_lock),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .rd_sel     (rd_sel),
        .rd_data    (rd_data),
        .pend_lf    (pend),
        .cnt_gray_lf(cnt_gray),
        .cfg        (cfg),
        .ev_req     (ev_req),
        .irq        (irq)
    );

    for (genvar g = 0; g < EV_N; g++) begin : g_ev
        wdg_evt_xfer u_xfer (
            .clk_a(clk_bus),
            .rst_a(rst_bus),
            .req_a(ev_req[g]),
            .clk_b(clk_lf),
            .rst_b(rst_lf),
            .pls_b(ev_pls[g])
        );
    end

    wdg_core u_core (
        .clk     (clk_lf),
        .rst     (rst_lf),
        .cfg_bus (cfg),
        .cfg_ld  (ev_pls[EV_CFG]),
        .int_clr (ev_pls[EV_INTCLR]),
        .cnt_clr (ev_pls[EV_CNTCLR]),
        .pend    (pend),
        .rst_req (rst_req),
        .cnt_gray(cnt_gray)
    );
endmodule

// File: tb/test_wdg_top.sv
module test_wdg_top;
    logic        clk_bus = 1'b0;
    logic        clk_lf  = 1'b0;
    logic        rst_bus = 1'b1;
    logic        rst_lf  = 1'b1;
    logic        wake_lock = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = 3'd0;
    logic [15:0] wr_data = 16'd0;
    logic [2:0]  rd_sel = 3'd0;
    logic [15:0] rd_data;
    logic        irq;
    logic        rst_req;

    int n_run  = 0;
    int n_fail = 0;

    localparam logic [2:0] AD_CTRL = 3'd0, AD_MATCH = 3'd1, AD_IGN = 3'd2, AD_CNT = 3'd3,
                           AD_INT = 3'd4, AD_MASK = 3'd5, AD_LOCK = 3'd6;

    wdg_top i_wdg_top (
        .clk_bus(clk_bus), .rst_bus(rst_bus), .clk_lf(clk_lf), .rst_lf(rst_lf),
        .wake_lock(wake_lock), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq), .rst_req(rst_req)
    );

    always #5 clk_bus = ~clk_bus;
    initial begin
        #3;
        forever #40 clk_lf = ~clk_lf;
    end

    task automatic chk_eq(input int got, input int exp, input string what);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", what, got, exp);
        end
    endtask

    task automatic chk_rng(input int got, input int lo, input int hi, input string what);
        n_run++;
        if (got < lo || got > hi) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d..%0d", what, got, lo, hi);
        end
    endtask

    task automatic wait_lf(input int n);
        repeat (n) @(negedge clk_lf);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk_bus);
        wr_en = 1'b1; wr_sel = a; wr_data = d;
        @(negedge clk_bus);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int d);
        @(negedge clk_bus);
        rd_sel = a;
        #1 d = int'(rd_data);
    endtask

    task automatic do_reset();
        rst_bus = 1'b1; rst_lf = 1'b1;
        wait_lf(3);
        rst_bus = 1'b0; rst_lf = 1'b0;
        wait_lf(2);
    endtask

    task automatic t_reset_values();
        int v;
        do_reset();
        rd(AD_CTRL, v);  chk_eq(v, 0, "R10 control");
        rd(AD_MATCH, v); chk_eq(v, 4096, "R10 match");
        rd(AD_IGN, v);   chk_eq(v, 0, "R10 ignore");
        rd(AD_CNT, v);   chk_eq(v, 0, "R10 counter");
        rd(AD_INT, v);   chk_eq(v, 0, "R10 pending");
        rd(AD_MASK, v);  chk_eq(v, 1, "R10 mask");
        rd(AD_LOCK, v);  chk_eq(v, 0, "R10 lock");
        chk_eq(int'(irq), 0, "R10 irq");
        chk_eq(int'(rst_req), 0, "R10 rst_req");
    endtask

    task automatic t_counting();
        int c1, c2;
        do_reset();
        wr(AD_CTRL, 16'd1);
        wait_lf(30);
        wr(AD_CTRL, 16'd0);
        wait_lf(6);
        rd(AD_CNT, c1); chk_rng(c1, 28, 32, "R1 one step per slow cycle");
        wait_lf(10);
        rd(AD_CNT, c2); chk_eq(c2, c1, "R1 held while disabled");
    endtask

    task automatic t_ignore();
        int v;
        do_reset();
        wr(AD_CTRL, 16'd1);
        wait_lf(40);
        rd(AD_INT, v); chk_eq(v, 0, "R2 no match with all bits compared");
        wr(AD_CTRL, 16'd0);
        wait_lf(6);
        wr(AD_IGN, 16'd12);
        wr(AD_MATCH, 16'd5);
        wr(AD_CTRL, 16'd1);
        wait_lf(24);
        rd(AD_INT, v); chk_eq(v, 1, "R2 match on low bits only");
        chk_eq(int'(irq), 1, "R6 irq follows pending when unmasked");
    endtask

    task automatic t_reset_time(input int ign, input int mt, input int third);
        int n, v;
        do_reset();
        wr(AD_IGN, 16'(ign));
        wr(AD_MATCH, 16'(mt));
        wr(AD_CTRL, 16'd1);
        n = 0;
        while (!rst_req && n < 200) begin
            @(negedge clk_lf);
            n++;
        end
        chk_rng(n, third + 1, third + 7, "R3 reset on third unserviced match");
        wait_lf(20);
        wr(AD_INT, 16'd1);
        wait_lf(10);
        chk_eq(int'(rst_req), 1, "R5 reset request held");
        rd(AD_CNT, v); chk_rng(v, third + 20, 65535, "R1 counter runs past match");
        do_reset();
        chk_eq(int'(rst_req), 0, "R5 system reset drops request");
    endtask

    task automatic t_feed();
        int seen;
        seen = 0;
        do_reset();
        wr(AD_IGN, 16'd12);
        wr(AD_MATCH, 16'd5);
        wr(AD_CTRL, 16'd1);
        for (int i = 0; i < 15; i++) begin
            wait_lf(10);
            if (rst_req) seen = 1;
            wr(AD_INT, 16'd1);
        end
        chk_eq(seen, 0, "R4 regular clears prevent reset");
        chk_eq(int'(rst_req), 0, "R4 no reset at end of feeding");
    endtask

    task automatic t_mask();
        int v, n;
        do_reset();
        wr(AD_MASK, 16'd0);
        wr(AD_IGN, 16'd12);
        wr(AD_MATCH, 16'd5);
        wr(AD_CTRL, 16'd1);
        wait_lf(24);
        rd(AD_INT, v); chk_eq(v, 1, "R6 pending while masked");
        chk_eq(int'(irq), 0, "R6 irq blocked by mask");
        n = 0;
        while (!rst_req && n < 80) begin
            @(negedge clk_lf);
            n++;
        end
        chk_eq(int'(rst_req), 1, "R6 mask does not stop reset");
        wr(AD_MASK, 16'd1);
        repeat (3) @(negedge clk_bus);
        chk_eq(int'(irq), 1, "R6 irq after unmask");
    endtask

    task automatic t_lock();
        int v;
        do_reset();
        wr(AD_LOCK, 16'd3);
        rd(AD_LOCK, v); chk_eq(v, 3, "R7 lock closes");
        wr(AD_MATCH, 16'd100);
        wr(AD_CTRL, 16'd1);
        rd(AD_MATCH, v); chk_eq(v, 4096, "R7 match write dropped when locked");
        rd(AD_CTRL, v);  chk_eq(v, 0, "R7 enable write dropped when locked");
        wr(AD_LOCK, 16'd2);
        wr(AD_LOCK, 16'd1);
        rd(AD_LOCK, v); chk_eq(v, 1, "R7 wrong order only reaches first step");
        wr(AD_IGN, 16'd7);
        rd(AD_IGN, v); chk_eq(v, 0, "R7 ignore write dropped half open");
        wr(AD_LOCK, 16'd2);
        rd(AD_LOCK, v); chk_eq(v, 0, "R7 two-step unlock opens");
        wr(AD_MATCH, 16'd100);
        rd(AD_MATCH, v); chk_eq(v, 100, "R7 match write accepted when open");
    endtask

    task automatic t_wake();
        int v;
        do_reset();
        @(negedge clk_bus); wake_lock = 1'b1;
        @(negedge clk_bus); wake_lock = 1'b0;
        rd(AD_LOCK, v); chk_eq(v, 3, "R8 sleep exit locks");
        wr(AD_MATCH, 16'd77);
        rd(AD_MATCH, v); chk_eq(v, 4096, "R8 match kept after sleep exit");
    endtask

    task automatic t_cnt_clear();
        int v;
        do_reset();
        wr(AD_CTRL, 16'd1);
        wait_lf(20);
        wr(AD_CNT, 16'd0);
        wait_lf(10);
        wr(AD_CTRL, 16'd0);
        wait_lf(6);
        rd(AD_CNT, v); chk_rng(v, 21, 40, "R9 clear ignored while enabled");
        wr(AD_CNT, 16'd0);
        wait_lf(8);
        rd(AD_CNT, v); chk_eq(v, 0, "R9 clear while disabled");
    endtask

    task automatic t_enable_clears();
        int v;
        do_reset();
        wr(AD_IGN, 16'd12);
        wr(AD_MATCH, 16'd5);
        wr(AD_CTRL, 16'd1);
        wait_lf(16);
        wr(AD_CTRL, 16'd0);
        wait_lf(6);
        rd(AD_INT, v); chk_eq(v, 1, "R11 pending before re-enable");
        wr(AD_IGN, 16'd0);
        wr(AD_MATCH, 16'd4096);
        wr(AD_CTRL, 16'd1);
        wait_lf(10);
        rd(AD_INT, v); chk_eq(v, 0, "R11 enable clears pending");
    endtask

    initial begin
        repeat (200000) @(posedge clk_bus);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset_values();
        t_counting();
        t_ignore();
        t_reset_time(12, 5, 37);
        t_reset_time(13, 3, 19);
        t_feed();
        t_mask();
        t_lock();
        t_wake();
        t_cnt_clear();
        t_enable_clears();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule